// File: doc/BRIEF.md
# Two-Channel Digital Potentiometer Serial Slave

This block is the control side of an addressable two-channel digital potentiometer. It watches a two-wire serial bus (SCL and SDA, open drain) by oversampling both lines with the system clock. It recognises bus start and stop conditions. It answers one 7-bit address, made of a fixed 4-bit device code and a 3-bit board strap, so up to eight such blocks can share a bus.

A master sets a wiper with a three-byte write:
- the address byte with the direction bit low;
- a channel-select command;
- the new 8-bit wiper code.

A master reads with only the address byte, direction bit high. The block then returns channel 0 followed by channel 1 for as long as the master acknowledges. The two wiper codes leave the block as parallel outputs for the resistor array. The block drives SDA only through a pull-down enable.

Top module: `dpot_i2c_slave`

## Requirements
- R1: After reset both wiper outputs hold 0x80 and the SDA pull-down enable is low.
- R2: An address byte is acknowledged only when its upper seven bits equal binary 0101 followed by the 3-bit strap input. The least significant bit is the direction: 0 means write, 1 means read. Any other address gets no acknowledge, and the rest of that transfer leaves both wipers unchanged.
- R3: In a write, command byte 0xA9 selects wiper 0 and 0xAA selects wiper 1. The next byte is stored into the selected wiper, and the other wiper keeps its value.
- R4: Every code from 0x00 to 0xFF is stored and returned unchanged, including both end values.
- R5: In a read, the block sends wiper 0 first and wiper 1 second, most significant bit first. It keeps alternating between the two for as long as the master acknowledges.
- R6: The block acknowledges an accepted address, command or data byte by pulling SDA low during the ninth clock. It changes its pull-down only while SCL is low.
- R7: A command byte other than 0xA9 or 0xAA is not acknowledged. The block then ignores the bus until the next start, so a following data byte is neither acknowledged nor stored.
- R8: When the master does not acknowledge a read byte, the block releases SDA and drives nothing until the next start or stop.
- R9: A falling SDA edge while SCL is high is a start, and a rising SDA edge while SCL is high is a stop. A start always restarts address reception, even in the middle of a byte or as a repeated start. Either condition releases SDA. A write cut off before its data byte is complete leaves both wipers unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad (wired-AND of all drivers) |
| strap_i | input | 3 | Board strap forming the low three address bits |
| wiper0_o | output | 8 | Current code of wiper 0 |
| wiper1_o | output | 8 | Current code of wiper 1 |
| sda_pull_o | output | 1 | High to pull SDA low, low to release it |

## Verification
The bench builds the block with its default two-stage synchroniser. It runs the bus at ten system clocks per SCL phase, which leaves room for the three-clock input latency before each data change. The strap input is changed from one random transfer to the next, and a quarter of those transfers carry a wrong strap value. This brings address matching and rejection for all eight strap settings within reach. Directed sequences cover the cases random traffic seldom produces:
- both end codes;
- a read that wraps past wiper 1;
- an unknown command;
- a repeated start;
- a start in the middle of a data byte;
- a stop right after the command byte;
- the released line after a master NACK.

// File: rtl/dpot_pkg.sv
// Package: shared constants and state types for the two-channel
// potentiometer serial slave. Assumes 8-bit bus bytes.
package dpot_pkg;

    localparam int WIPER_W    = 8;
    localparam int NUM_WIPERS = 2;
    localparam int SEL_W      = (NUM_WIPERS > 1) ? $clog2(NUM_WIPERS) : 1;
    localparam int STRAP_W    = 3;
    localparam int BYTE_W     = 8;
    localparam int CNT_W      = $clog2(BYTE_W + 1);

    localparam logic [3:0]         DEV_CODE   = 4'b0101;
    localparam logic [BYTE_W-1:0]  CMD_SEL0   = 8'hA9;
    localparam logic [BYTE_W-1:0]  CMD_SEL1   = 8'hAA;
    localparam logic [WIPER_W-1:0] WIPER_INIT = 8'h80;

    typedef enum logic [2:0] {
        LS_IDLE,
        LS_RECV,
        LS_RECV_ACK,
        LS_SEND,
        LS_SEND_ACK,
        LS_PARK
    } link_state_t;

    typedef enum logic [1:0] {
        FR_ADDR,
        FR_CMD,
        FR_DATA
    } field_t;

endpackage

// File: rtl/dpot_sync.sv
// Module: multi-bit, multi-stage input synchroniser.
// Each bit gets its own independent flop chain of STAGES flops.
// Assumes the inputs are asynchronous level signals that change slowly
// relative to clk. STAGES must be at least 2.
module dpot_sync #(
    parameter int   WIDTH   = 2,
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic [STAGES-1:0] chain;

        // Shift the raw bit through the flop chain.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                chain <= {STAGES{RST_VAL}};
            end else begin
                chain <= {chain[STAGES-2:0], d_i[g]};
            end
        end

        assign q_o[g] = chain[STAGES-1];
    end

endmodule

// File: rtl/dpot_bus_cond.sv
// Module: bus condition detector.
// Turns synchronised SCL/SDA levels into single-cycle strobes:
// SCL rise, SCL fall, start and stop.
// Assumes both inputs come from the same synchroniser, so that they stay
// aligned in time.
module dpot_bus_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);

    logic scl_q;
    logic sda_q;

    // Remember the previous synchronised levels (idle bus is high).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    // Derive the edge and condition strobes from the old and new levels.
    always_comb begin
        scl_rise_o = scl_s & ~scl_q;
        scl_fall_o = ~scl_s & scl_q;
        start_o    = scl_s & scl_q & sda_q & ~sda_s;
        stop_o     = scl_s & scl_q & ~sda_q & sda_s;
    end

endmodule

// File: rtl/dpot_link.sv
// Module: byte-level protocol engine.
// It receives the address, command and data bytes and drives the
// acknowledge bits. It serialises wiper codes on reads, and it issues
// one-cycle write strobes to the wiper bank.
// Assumes single-cycle strobes from dpot_bus_cond. A start or stop
// strobe takes priority over any byte activity.
module dpot_link
    import dpot_pkg::*;
(
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 scl_rise_i,
    input  logic                                 scl_fall_i,
    input  logic                                 start_i,
    input  logic                                 stop_i,
    input  logic                                 sda_s,
    input  logic [STRAP_W-1:0]                   strap_i,
    input  logic [NUM_WIPERS-1:0][WIPER_W-1:0]   wiper_i,
    output logic                                 wr_en_o,
    output logic [SEL_W-1:0]                     wr_sel_o,
    output logic [WIPER_W-1:0]                   wr_data_o,
    output logic                                 sda_pull_o
);

    link_state_t        state;
    field_t             field;
    logic [CNT_W-1:0]   bit_cnt;
    logic [BYTE_W-1:0]  shreg;
    logic               is_read;
    logic               mst_ack;
    logic [SEL_W-1:0]   tgt;
    logic [SEL_W-1:0]   rd_idx;
    logic               addr_hit;
    logic [WIPER_W-1:0] next_tx;

    // Address comparison and selection of the next byte to transmit.
    always_comb begin
        addr_hit = (shreg[BYTE_W-1:1] == {DEV_CODE, strap_i});
        next_tx  = wiper_i[rd_idx];
    end

    // Protocol sequencing: byte shifting, acknowledges and wiper writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= LS_IDLE;
            field      <= FR_ADDR;
            bit_cnt    <= '0;
            shreg      <= '0;
            is_read    <= 1'b0;
            mst_ack    <= 1'b0;
            tgt        <= '0;
            rd_idx     <= '0;
            wr_en_o    <= 1'b0;
            wr_data_o  <= '0;
            sda_pull_o <= 1'b0;
        end else begin
            wr_en_o <= 1'b0;
            if (start_i) begin
                state      <= LS_RECV;
                field      <= FR_ADDR;
                bit_cnt    <= '0;
                sda_pull_o <= 1'b0;
            end else if (stop_i) begin
                state      <= LS_IDLE;
                sda_pull_o <= 1'b0;
            end else begin
                case (state)
                    LS_RECV: begin
                        if (scl_rise_i) begin
                            shreg   <= {shreg[BYTE_W-2:0], sda_s};
                            bit_cnt <= bit_cnt + 1'b1;
                        end else if (scl_fall_i && bit_cnt == CNT_W'(BYTE_W)) begin
                            bit_cnt <= '0;
                            case (field)
                                FR_ADDR: begin
                                    if (addr_hit) begin
                                        is_read    <= shreg[0];
                                        sda_pull_o <= 1'b1;
                                        state      <= LS_RECV_ACK;
                                    end else begin
                                        state <= LS_PARK;
                                    end
                                end
                                FR_CMD: begin
                                    if (shreg == CMD_SEL0) begin
                                        tgt        <= SEL_W'(0);
                                        sda_pull_o <= 1'b1;
                                        state      <= LS_RECV_ACK;
                                    end else if (shreg == CMD_SEL1) begin
                                        tgt        <= SEL_W'(1);
                                        sda_pull_o <= 1'b1;
                                        state      <= LS_RECV_ACK;
                                    end else begin
                                        state <= LS_PARK;
                                    end
                                end
                                default: begin
                                    wr_en_o    <= 1'b1;
                                    wr_data_o  <= shreg;
                                    sda_pull_o <= 1'b1;
                                    state      <= LS_RECV_ACK;
                                end
                            endcase
                        end
                    end
                    LS_RECV_ACK: begin
                        if (scl_fall_i) begin
                            bit_cnt <= '0;
                            if (field == FR_ADDR && is_read) begin
                                state      <= LS_SEND;
                                shreg      <= wiper_i[0];
                                sda_pull_o <= ~wiper_i[0][WIPER_W-1];
                                rd_idx     <= SEL_W'(1);
                            end else begin
                                state      <= LS_RECV;
                                sda_pull_o <= 1'b0;
                                field      <= (field == FR_CMD) ? FR_DATA : FR_CMD;
                            end
                        end
                    end
                    LS_SEND: begin
                        if (scl_fall_i) begin
                            if (bit_cnt == CNT_W'(BYTE_W - 1)) begin
                                bit_cnt    <= '0;
                                sda_pull_o <= 1'b0;
                                state      <= LS_SEND_ACK;
                            end else begin
                                shreg      <= {shreg[BYTE_W-2:0], 1'b0};
                                sda_pull_o <= ~shreg[BYTE_W-2];
                                bit_cnt    <= bit_cnt + 1'b1;
                            end
                        end
                    end
                    LS_SEND_ACK: begin
                        if (scl_rise_i) begin
                            mst_ack <= ~sda_s;
                        end else if (scl_fall_i) begin
                            if (mst_ack) begin
                                state      <= LS_SEND;
                                shreg      <= next_tx;
                                sda_pull_o <= ~next_tx[WIPER_W-1];
                                rd_idx     <= rd_idx + 1'b1;
                            end else begin
                                state <= LS_PARK;
                            end
                        end
                    end
                    default: begin
                    end
                endcase
            end
        end
    end

    assign wr_sel_o = tgt;

endmodule

// File: rtl/dpot_wiper_bank.sv
// Module: wiper code registers.
// There is one register per channel, loaded by a single-cycle write strobe.
// Assumes at most one write per cycle, which the protocol engine ensures.
module dpot_wiper_bank
    import dpot_pkg::*;
(
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               wr_en_i,
    input  logic [SEL_W-1:0]                   wr_sel_i,
    input  logic [WIPER_W-1:0]                 wr_data_i,
    output logic [NUM_WIPERS-1:0][WIPER_W-1:0] wiper_o
);

    for (genvar g = 0; g < NUM_WIPERS; g++) begin : g_wiper
        // Hold the code of channel g and load it on a matching write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                wiper_o[g] <= WIPER_INIT;
            end else if (wr_en_i && wr_sel_i == SEL_W'(g)) begin
                wiper_o[g] <= wr_data_i;
            end
        end
    end

endmodule

// File: rtl/dpot_i2c_slave.sv
// Module: top of the two-channel potentiometer serial slave.
// It synchronises the bus lines, detects the bus conditions, runs the
// protocol and holds the wiper codes.
// Assumes each SCL phase lasts well over SYNC_STAGES+2 clk cycles.
// sda_pull_o must drive an open-drain pad.
module dpot_i2c_slave
    import dpot_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    input  logic [STRAP_W-1:0] strap_i,
    output logic [7:0]         wiper0_o,
    output logic [7:0]         wiper1_o,
    output logic               sda_pull_o
);

    logic [1:0]                         bus_s;
    logic                               scl_rise;
    logic                               scl_fall;
    logic                               start_det;
    logic                               stop_det;
    logic                               wr_en;
    logic [SEL_W-1:0]                   wr_sel;
    logic [WIPER_W-1:0]                 wr_data;
    logic [NUM_WIPERS-1:0][WIPER_W-1:0] wipers;

    dpot_sync #(
        .WIDTH   (2),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (1'b1)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({scl_i, sda_i}),
        .q_o   (bus_s)
    );

    dpot_bus_cond u_cond (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_s      (bus_s[1]),
        .sda_s      (bus_s[0]),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_det),
        .stop_o     (stop_det)
    );

    dpot_link u_link (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_rise_i (scl_rise),
        .scl_fall_i (scl_fall),
        .start_i    (start_det),
        .stop_i     (stop_det),
        .sda_s      (bus_s[0]),
        .strap_i    (strap_i),
        .wiper_i    (wipers),
        .wr_en_o    (wr_en),
        .wr_sel_o   (wr_sel),
        .wr_data_o  (wr_data),
        .sda_pull_o (sda_pull_o)
    );

    dpot_wiper_bank u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_sel_i  (wr_sel),
        .wr_data_i (wr_data),
        .wiper_o   (wipers)
    );

    assign wiper0_o = wipers[0];
    assign wiper1_o = wipers[1];

endmodule

// File: rtl/dpot_i2c_slave_chk.sv
// Module: property checker for dpot_i2c_slave, attached by bind.
// It observes the top-level ports plus the start and stop strobes.
module dpot_i2c_slave_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_i,
    input logic [7:0] wiper0_o,
    input logic [7:0] wiper1_o,
    input logic       sda_pull_o,
    input logic       start_det,
    input logic       stop_det
);

    // R1: the first cycle out of reset shows the reset state.
    p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (wiper0_o == 8'h80 && wiper1_o == 8'h80 && !sda_pull_o));

    // R6: the pull-down moves only while SCL is low (bus conditions excepted).
    p_pull_scl_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sda_pull_o) && $past(!start_det && !stop_det)) |-> !scl_i);

    // R3: a wiper changes only while SCL is low.
    p_wiper_scl_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(wiper0_o) || !$stable(wiper1_o)) |-> !scl_i);

    // R3: a write never changes both wipers in the same cycle.
    p_single_wiper_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(!$stable(wiper0_o) && !$stable(wiper1_o)));

    // R9: a stop releases SDA.
    p_stop_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_pull_o);

    // R9: a start releases SDA.
    p_start_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> !sda_pull_o);

endmodule

bind dpot_i2c_slave dpot_i2c_slave_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_i),
    .wiper0_o   (wiper0_o),
    .wiper1_o   (wiper1_o),
    .sda_pull_o (sda_pull_o),
    .start_det  (start_det),
    .stop_det   (stop_det)
);

// File: tb/dpot_i2c_slave_tb.sv
// Bench: a bus master model with an open-drain wired-AND SDA.
// It runs directed corner cases and seeded random transfers, and checks
// the results against a bench-side model of the two wipers.
module dpot_i2c_slave_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic [2:0] strap = 3'b101;
    logic [7:0] wiper0;
    logic [7:0] wiper1;
    logic       sda_pull;
    wire        sda_bus = sda_m & ~sda_pull;

    int unsigned n_chk = 0;
    int unsigned n_bad = 0;
    bit          done = 1'b0;
    logic [7:0]  m_w0 = 8'h80;
    logic [7:0]  m_w1 = 8'h80;

    always #2.5 clk = ~clk;

    dpot_i2c_slave u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_m),
        .sda_i      (sda_bus),
        .strap_i    (strap),
        .wiper0_o   (wiper0),
        .wiper1_o   (wiper1),
        .sda_pull_o (sda_pull)
    );

    function automatic logic [7:0] addr_byte(input logic [2:0] s, input logic rd);
        return {4'b0101, s, rd};
    endfunction

    function automatic logic [7:0] cmd_byte(input logic idx);
        return idx ? 8'hAA : 8'hA9;
    endfunction

    function automatic logic [7:0] exp_read(input int k);
        return (k % 2 == 0) ? m_w0 : m_w1;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_io(input logic drv, output logic seen);
        wait_n(5); sda_m = drv;
        wait_n(5); scl_m = 1'b1;
        wait_n(5); seen = sda_bus;
        wait_n(5); scl_m = 1'b0;
    endtask

    task automatic bus_start();
        sda_m = 1'b1; scl_m = 1'b1; wait_n(10);
        sda_m = 1'b0; wait_n(10);
        scl_m = 1'b0;
    endtask

    task automatic bus_rstart();
        wait_n(5); sda_m = 1'b1;
        wait_n(5); scl_m = 1'b1;
        wait_n(10); sda_m = 1'b0;
        wait_n(10); scl_m = 1'b0;
    endtask

    task automatic bus_stop();
        wait_n(5); sda_m = 1'b0;
        wait_n(5); scl_m = 1'b1;
        wait_n(10); sda_m = 1'b1;
        wait_n(10);
    endtask

    task automatic put_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) bit_io(b[i], s);
        bit_io(1'b1, ack);
    endtask

    task automatic get_byte(input logic give_ack, output logic [7:0] v);
        logic s;
        v = '0;
        for (int i = 0; i < 8; i++) begin
            bit_io(1'b1, s);
            v = {v[6:0], s};
        end
        bit_io(give_ack ? 1'b0 : 1'b1, s);
    endtask

    task automatic write_txn(input logic [2:0] s, input logic [7:0] cmd, input logic [7:0] val,
                             output logic a0, output logic a1, output logic a2);
        bus_start();
        put_byte(addr_byte(s, 1'b0), a0);
        put_byte(cmd, a1);
        put_byte(val, a2);
        bus_stop();
    endtask

    // Watchdog: ends a hung run as a failure.
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    // Main stimulus.
    initial begin
        logic a0, a1, a2, s;
        logic [7:0] v;
        void'($urandom(32'd20240611));
        wait_n(10);
        rst_n = 1'b1;
        wait_n(2);
        chk("R1 wiper0 reset", 32'(wiper0), 32'h80);
        chk("R1 wiper1 reset", 32'(wiper1), 32'h80);
        chk("R1 pull reset", 32'(sda_pull), 32'h0);

        // R3/R6: write wiper 0.
        write_txn(strap, 8'hA9, 8'h55, a0, a1, a2);
        m_w0 = 8'h55;
        chk("R2 addr ack", 32'(a0), 0);
        chk("R6 cmd ack", 32'(a1), 0);
        chk("R6 data ack", 32'(a2), 0);
        chk("R3 wiper0 written", 32'(wiper0), 32'(m_w0));
        chk("R3 wiper1 kept", 32'(wiper1), 32'(m_w1));

        write_txn(strap, 8'hAA, 8'h3C, a0, a1, a2);
        m_w1 = 8'h3C;
        chk("R3 wiper1 written", 32'(wiper1), 32'(m_w1));
        chk("R3 wiper0 kept", 32'(wiper0), 32'(m_w0));

        // R4: both end codes.
        write_txn(strap, 8'hA9, 8'h00, a0, a1, a2); m_w0 = 8'h00;
        write_txn(strap, 8'hAA, 8'hFF, a0, a1, a2); m_w1 = 8'hFF;
        chk("R4 wiper0 zero", 32'(wiper0), 32'h00);
        chk("R4 wiper1 full", 32'(wiper1), 32'hFF);

        // R5/R8: read with wrap, then master NACK.
        bus_start();
        put_byte(addr_byte(strap, 1'b1), a0);
        chk("R2 read addr ack", 32'(a0), 0);
        for (int k = 0; k < 3; k++) begin
            get_byte(k < 2, v);
            chk("R5 read order", 32'(v), 32'(exp_read(k)));
        end
        for (int k = 0; k < 9; k++) begin
            bit_io(1'b1, s);
            chk("R8 released after nack", 32'(s), 1);
        end
        bus_stop();

        // R2: wrong strap is ignored.
        write_txn(strap ^ 3'b010, 8'hA9, 8'h11, a0, a1, a2);
        chk("R2 wrong addr nack", 32'(a0), 1);
        chk("R2 data after wrong addr nack", 32'(a2), 1);
        chk("R2 wiper0 unchanged", 32'(wiper0), 32'(m_w0));

        // R7: unknown command.
        write_txn(strap, 8'h55, 8'h22, a0, a1, a2);
        chk("R7 addr ack", 32'(a0), 0);
        chk("R7 bad cmd nack", 32'(a1), 1);
        chk("R7 data nack", 32'(a2), 1);
        chk("R7 wiper0 unchanged", 32'(wiper0), 32'(m_w0));
        chk("R7 wiper1 unchanged", 32'(wiper1), 32'(m_w1));

        // R9: repeated start from write into read.
        bus_start();
        put_byte(addr_byte(strap, 1'b0), a0);
        put_byte(8'hA9, a1);
        put_byte(8'h77, a2);
        m_w0 = 8'h77;
        bus_rstart();
        put_byte(addr_byte(strap, 1'b1), a0);
        chk("R9 repeated start addr ack", 32'(a0), 0);
        get_byte(1'b1, v);
        chk("R9 read after rstart w0", 32'(v), 32'(m_w0));
        get_byte(1'b0, v);
        chk("R9 read after rstart w1", 32'(v), 32'(m_w1));
        bus_stop();

        // R9: start in the middle of a data byte aborts it.
        bus_start();
        put_byte(addr_byte(strap, 1'b0), a0);
        put_byte(8'hA9, a1);
        for (int i = 0; i < 4; i++) bit_io(1'b0, s);
        bus_rstart();
        put_byte(addr_byte(strap, 1'b0), a0);
        put_byte(8'hAA, a1);
        put_byte(8'h12, a2);
        bus_stop();
        m_w1 = 8'h12;
        chk("R9 aborted byte left wiper0", 32'(wiper0), 32'(m_w0));
        chk("R9 restarted write wiper1", 32'(wiper1), 32'(m_w1));

        // R9: stop right after the command byte.
        bus_start();
        put_byte(addr_byte(strap, 1'b0), a0);
        put_byte(8'hAA, a1);
        bus_stop();
        chk("R9 stop after cmd wiper1", 32'(wiper1), 32'(m_w1));
        chk("R9 pull released after stop", 32'(sda_pull), 0);

        // Random transfers with changing straps.
        for (int it = 0; it < 30; it++) begin
            logic       idx;
            logic [7:0] val;
            logic       bad;
            logic [2:0] use_s;
            strap = 3'($urandom % 8);
            idx   = 1'($urandom % 2);
            val   = 8'($urandom % 256);
            bad   = (($urandom % 4) == 0);
            use_s = bad ? (strap ^ 3'(1 + $urandom % 7)) : strap;
            write_txn(use_s, cmd_byte(idx), val, a0, a1, a2);
            if (!bad) begin
                if (idx) m_w1 = val; else m_w0 = val;
            end
            chk("R2 random addr ack", 32'(a0), bad ? 1 : 0);
            chk("R3 random wiper0", 32'(wiper0), 32'(m_w0));
            chk("R3 random wiper1", 32'(wiper1), 32'(m_w1));
            bus_start();
            put_byte(addr_byte(strap, 1'b1), a0);
            get_byte(1'b1, v);
            chk("R5 random read w0", 32'(v), 32'(exp_read(0)));
            get_byte(1'b0, v);
            chk("R5 random read w1", 32'(v), 32'(exp_read(1)));
            bus_stop();
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule